// File: doc/BRIEF.md
# Split Four-Bit Binary Ripple Counter

This block is a four-bit counter built from two independent sections. A one-bit toggle section is advanced by falling edges on a first count input. A three-bit binary section, which divides by eight, is advanced by falling edges on a second count input. Both count inputs are treated as asynchronous. Each one passes through a synchroniser and an edge detector before it can touch the count, and all state is clocked by a single system clock.

Output bit 0 is the toggle section. Bits 3 to 1 are the divide-by-eight section, with bit 1 as its least significant bit. To count modulo 16, wire output bit 0 back to the second count input outside the block and apply pulses to the first count input. Two clear inputs form a gated clear: the count is zeroed only while both of them are high. A synchronous active-low system reset clears the count and the synchronisers.

Top module: `split_ripple_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, `count_o` is 0 after that edge.
- R2: A falling edge on `cnt_a_in` inverts `count_o[0]`. The change takes effect at the third rising clock edge after the input changes, and each falling edge inverts the bit exactly once.
- R3: A falling edge on `cnt_b_in` adds one to `count_o[3:1]` with the same three-edge latency, and the value wraps from 7 to 0.
- R4: A rising edge on either count input, or an input held at a steady level, leaves `count_o` unchanged.
- R5: When `clr_a` and `clr_b` are both high at a rising clock edge, `count_o` is 0 after that edge. When only one of them is high, both sections keep counting.
- R6: An active gated clear wins over an advance that falls in the same clock edge. The advance is discarded and does not reappear later.
- R7: The sections are independent: `cnt_a_in` never changes `count_o[3:1]`, and `cnt_b_in` never changes `count_o[0]`.
- R8: With `count_o[0]` wired to `cnt_b_in`, successive pulses on `cnt_a_in` step `count_o` through 0 to 15 in binary order and then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_a_in | input | 1 | Asynchronous count input for the toggle section |
| cnt_b_in | input | 1 | Asynchronous count input for the divide-by-eight section |
| clr_a | input | 1 | First leg of the gated clear |
| clr_b | input | 1 | Second leg of the gated clear |
| count_o | output | 4 | Count value: bit 0 is the toggle section, bits 3:1 are the divide-by-eight section |

## Verification
The bench drives each clear leg on its own while pulses keep arriving. A design that ORed the legs instead of ANDing them would zero the count there. It places a clear on the exact edge where a synchronised fall lands. A design with the wrong priority would show a toggle that survives the clear, or a toggle that appears one cycle later. It holds count inputs high for long stretches and pulses the upper section past seven. This exposes designs that count on level or on the rising edge, and designs that saturate at seven instead of wrapping. The external feedback loop runs the full sixteen-step cycle and catches cross-coupling between the sections as well as a wrong bit order.

// File: rtl/split_ctr_pkg.sv
// Shared types for the split ripple counter.
// Assumes: one system clock domain; count inputs are asynchronous.
package split_ctr_pkg;

    // Edge events reported by a synchroniser for one input line
    typedef struct packed {
        logic fall;
        logic rise;
    } edge_ev_t;

endpackage

// File: rtl/ctr_edge_sync.sv
// Brings an asynchronous count line into the clock domain and reports edges.
// Assumes: the input level is held for more than STAGES+1 clock periods.
// Latency: an input change shows as an event STAGES clocks later.
module ctr_edge_sync
    import split_ctr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     din,
    output edge_ev_t ev
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift register: first STAGES flops synchronise, the last holds the prior level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], din};
        end
    end

    // Decode edges from the settled level and its predecessor
    always_comb begin
        ev.fall = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
        ev.rise = ~chain[CHAIN_W-1] & chain[CHAIN_W-2];
    end

endmodule

// File: rtl/ctr_toggle_stage.sv
// Divide-by-two section: inverts its bit on each advance pulse.
// Assumes: adv is a single-cycle pulse; clr has priority over adv.
module ctr_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);

    // State bit with reset, gated clear, then toggle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= 1'b0;
        end else if (adv) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/ctr_binary_stage.sv
// Binary up-counter section of WIDTH bits; wraps naturally at 2**WIDTH.
// Assumes: adv is a single-cycle pulse; clr has priority over adv.
module ctr_binary_stage #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    // Count register with reset, gated clear, then increment
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (adv) begin
            q <= q + ONE;
        end
    end

endmodule

// File: rtl/split_ripple_counter.sv
// Split counter top: toggle section on count input A, binary section on B.
// Assumes: count inputs are slow relative to clk; external feedback of
// count_o[0] to cnt_b_in yields a full-width binary count.
module split_ripple_counter
    import split_ctr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HI_W        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_a_in,
    input  logic          cnt_b_in,
    input  logic          clr_a,
    input  logic          clr_b,
    output logic [HI_W:0] count_o
);

    edge_ev_t        ev_a;
    edge_ev_t        ev_b;
    logic            clear_req;
    logic            lo_q;
    logic [HI_W-1:0] hi_q;

    // Gated clear: both legs must be asserted
    always_comb clear_req = clr_a & clr_b;

    ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_a_in),
        .ev    (ev_a)
    );

    ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cnt_b_in),
        .ev    (ev_b)
    );

    ctr_toggle_stage u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_req),
        .adv   (ev_a.fall),
        .q     (lo_q)
    );

    ctr_binary_stage #(.WIDTH(HI_W)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear_req),
        .adv   (ev_b.fall),
        .q     (hi_q)
    );

    // Pack the two sections into the output word
    always_comb count_o = {hi_q, lo_q};

endmodule

// File: rtl/split_ripple_counter_chk.sv
// Assertion checker bound to split_ripple_counter; watches ports only.
module split_ripple_counter_chk #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HI_W        = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_a_in,
    input logic          cnt_b_in,
    input logic          clr_a,
    input logic          clr_b,
    input logic [HI_W:0] count_o
);

    localparam int unsigned LAT = SYNC_STAGES + 2;
    localparam int unsigned ARM = 2 * LAT + 1;

    logic [7:0] age;
    logic       armed;

    // Count edges since reset so past-value checks only see live inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 8'hFF) begin
            age <= age + 8'd1;
        end
    end

    always_comb armed = (age >= 8'(ARM));

    // R5
    gated_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b) |=> (count_o == '0));

    // R3
    hi_wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(clr_a && clr_b) && (count_o[HI_W:1] != $past(count_o[HI_W:1])))
        |-> (count_o[HI_W:1] == HI_W'($past(count_o[HI_W:1]) + 1'b1)));

    // R4
    lo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(clr_a && clr_b) && (count_o[0] != $past(count_o[0])))
        |-> ($past(cnt_a_in, LAT) && !$past(cnt_a_in, LAT - 1)));

    // R7
    hi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(clr_a && clr_b) && (count_o[HI_W:1] != $past(count_o[HI_W:1])))
        |-> ($past(cnt_b_in, LAT) && !$past(cnt_b_in, LAT - 1)));

    // R2
    lo_fall_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(clr_a && clr_b) && $past(cnt_a_in, LAT) && !$past(cnt_a_in, LAT - 1))
        |-> (count_o[0] != $past(count_o[0])));

endmodule

bind split_ripple_counter split_ripple_counter_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .HI_W        (HI_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_a_in (cnt_a_in),
    .cnt_b_in (cnt_b_in),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .count_o  (count_o)
);

// File: tb/sim_split_ripple_counter.sv
module sim_split_ripple_counter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_drv, b_drv, clr_a, clr_b, loop_en;
    logic       b_wire;
    logic [3:0] count_o;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_lo = 0;
    int m_hi = 0;
    bit aq[$];
    bit bq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign b_wire = loop_en ? count_o[0] : b_drv;

    split_ripple_counter u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_a_in (a_drv),
        .cnt_b_in (b_wire),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .count_o  (count_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: inputs take effect three edges after they change
    always @(posedge clk) begin
        bit fa, fb;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0;
            aq = '{0, 0, 0};
            bq = '{0, 0, 0};
        end else begin
            fa = aq[0] && !aq[1];
            fb = bq[0] && !bq[1];
            if (clr_a && clr_b) begin
                m_lo = 0; m_hi = 0;
            end else begin
                if (fa) m_lo = 1 - m_lo;
                if (fb) m_hi = (m_hi + 1) % 8;
            end
            void'(aq.pop_front()); aq.push_back(a_drv);
            void'(bq.pop_front()); bq.push_back(b_wire);
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done)
            check(cur_req, count_o, 4'((m_hi << 1) | m_lo));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a(input int hi, input int lo);
        a_drv = 1'b1; tick(hi);
        a_drv = 1'b0; tick(lo);
    endtask

    task automatic pulse_b(input int hi, input int lo);
        b_drv = 1'b1; tick(hi);
        b_drv = 1'b0; tick(lo);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; a_drv = 1'b0; b_drv = 1'b0;
        clr_a = 1'b0; clr_b = 1'b0; loop_en = 1'b0;
        tick(3);
        cmp_en = 1;
        check("R1", count_o, 4'b0000);   // R1 reset state
        rst_n = 1'b1;
        tick(2);

        // R2: three falling edges on A leave bit 0 set
        cur_req = "R2";
        for (int i = 0; i < 3; i++) pulse_a(4, 6);
        check("R2", count_o, 4'b0001);

        // R4: A held high for a long time changes nothing
        cur_req = "R4";
        a_drv = 1'b1; tick(20);
        check("R4", count_o, 4'b0001);
        a_drv = 1'b0; tick(6);
        check("R2", count_o, 4'b0000);

        // R3: seven B pulses reach 7, two more wrap to 1
        cur_req = "R3";
        for (int i = 0; i < 7; i++) pulse_b(4, 6);
        check("R3", count_o, 4'b1110);
        for (int i = 0; i < 2; i++) pulse_b(4, 6);
        check("R3", count_o, 4'b0010);

        // R7: an A pulse leaves the upper section alone
        cur_req = "R7";
        pulse_a(4, 6);
        check("R7", count_o, 4'b0011);

        // R5: one clear leg at a time does not stop counting
        cur_req = "R5";
        clr_a = 1'b1;
        pulse_b(4, 6);
        check("R5", count_o, 4'b0101);
        clr_a = 1'b0; clr_b = 1'b1;
        pulse_a(4, 6);
        check("R5", count_o, 4'b0100);
        clr_a = 1'b1; tick(1);
        check("R5", count_o, 4'b0000);
        clr_a = 1'b0; clr_b = 1'b0; tick(2);

        // R6: clear on the same edge as a synchronised fall on A
        cur_req = "R6";
        a_drv = 1'b1; tick(4);
        a_drv = 1'b0; tick(2);
        clr_a = 1'b1; clr_b = 1'b1; tick(1);
        check("R6", count_o, 4'b0000);
        clr_a = 1'b0; clr_b = 1'b0; tick(6);
        check("R6", count_o, 4'b0000);

        // R6: same for B
        b_drv = 1'b1; tick(4);
        b_drv = 1'b0; tick(2);
        clr_a = 1'b1; clr_b = 1'b1; tick(1);
        check("R6", count_o, 4'b0000);
        clr_a = 1'b0; clr_b = 1'b0; tick(6);
        check("R6", count_o, 4'b0000);

        // R8: feedback of bit 0 into B gives a full binary count
        cur_req = "R8";
        loop_en = 1'b1;
        for (int i = 0; i < 5; i++) pulse_a(5, 8);
        check("R8", count_o, 4'd5);
        for (int i = 0; i < 10; i++) pulse_a(5, 8);
        check("R8", count_o, 4'd15);
        pulse_a(5, 8);
        check("R8", count_o, 4'd0);
        for (int i = 0; i < 3; i++) pulse_a(5, 8);
        check("R8", count_o, 4'd3);
        loop_en = 1'b0;

        // R1: system reset in mid-run
        cur_req = "R1";
        rst_n = 1'b0; tick(2);
        check("R1", count_o, 4'b0000);
        rst_n = 1'b1; tick(4);
        check("R1", count_o, 4'b0000);

        finish_run();
    end

endmodule